// File: doc/BRIEF.md
# Handshaking Parallel Port Peripheral

This block sits on a processor's register bus and provides three 8-bit general-purpose ports, named A, B and C, plus a control register. The processor reaches the block with a chip select, single-cycle read and write strobes and a 2-bit register address. Every port has its own pin input, pin output and per-bit output-enable vectors, so the pad ring can be built around it.

A mode word configures the block. In plain mode, port A, port B and each nibble of port C are set as inputs or outputs independently. Written values are held in latches, and input pins are read live. Port A and port B can each be switched to strobed handshake operation instead. In that case fixed port C pins become the buffer-full, acknowledge or strobe, and interrupt lines for that port. Written into the control address with bit 7 clear, a byte sets or clears a single port C bit without touching the rest.

All pins are sampled on the rising clock edge. A handshake edge takes effect on the first edge at which the registered previous pin value differs from the present one. A read returns data in the same cycle. Flags that a read clears drop at the clock edge that ends the read cycle.

Top module: `hsk_pport`

## Requirements
- R1: Register address 0 reaches port A, 1 port B, 2 port C and 3 the control register. A mode word written to address 3 reads back unchanged from address 3.
- R2: Control byte fields are: bit 7 = 1 marks a mode word, bit 6 is ignored, bit 5 = port A handshake, bit 4 = port A input, bit 3 = port C bits 7:4 input, bit 2 = port B handshake, bit 1 = port B input, bit 0 = port C bits 3:0 input. A mode word of 0x80 (or 0xC0) makes every port an output with all output enables high, and each port's output carries the last value written to it.
- R3: In plain mode, each of port A, port B, C-high and C-low is independently input or output. Input groups have output enable 0 and read back the live pin values. Output groups read back their latched value.
- R4: Writing any mode word clears the A, B and C output latches and all handshake flags.
- R5: A write to address 3 with bit 7 clear loads bit 0 into port C bit number wdata[3:1] (0x09 sets bit 4, 0x08 clears it). It changes no other port C bit and leaves the control register as it was.
- R6: In port A handshake output mode, pin C7 is an active-low buffer-full flag, C6 is the acknowledge input and C3 is the interrupt. A CPU write to A drives C7 low and C3 low. A falling edge on C6 returns C7 high. A rising edge on C6 while C7 is high sets C3.
- R7: In port B handshake output mode, the same behaviour as R6 applies with buffer-full on C1, acknowledge on C2 and interrupt on C0.
- R8: In port A handshake input mode, port A output enable is 0 and C4 is the strobe input. A falling edge on C4 latches the port A pins and sets the buffer-full flag on C5. A rising edge on C4 sets the interrupt on C3. A CPU read of A returns the latched byte, even after the pins have changed, and clears both C5 and C3.
- R9: In port B handshake input mode, the same behaviour as R8 applies with strobe on C2, buffer-full on C1 and interrupt on C0.
- R10: After reset, the control register reads 0x9B (all plain inputs), all output enables are 0 and all output latches are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while cs and rd are high, otherwise 0 |
| aIn | input | 8 | Port A pin input |
| aOut | output | 8 | Port A pin output |
| aOe | output | 8 | Port A output enable per bit |
| bIn | input | 8 | Port B pin input |
| bOut | output | 8 | Port B pin output |
| bOe | output | 8 | Port B output enable per bit |
| cIn | input | 8 | Port C pin input, including handshake inputs |
| cOut | output | 8 | Port C pin output, including handshake flags |
| cOe | output | 8 | Port C output enable per bit |

## Verification
Plain mode is driven through a table of mode words, including the all-output, all-input, single-nibble and ignored-bit-6 cases. Each row writes distinct bytes to the latches and applies different pin bytes, so every readback shows whether it came from the latch or from the pins, and in port C it shows this per nibble. The handshake sequences step the acknowledge and strobe pins one edge at a time. The first step separates the falling-edge effect from the rising-edge effect. A later step changes the pins after the strobe, which separates a latched read from a live one. Set/reset commands and mode rewrites are then checked for the bits they must and must not disturb.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PortW   = 8;
  localparam int AddrW   = 2;
  localparam int BitIdxW = $clog2(PortW);
  localparam int HalfW   = PortW / 2;

  localparam logic [AddrW-1:0] AddrA   = 2'd0;
  localparam logic [AddrW-1:0] AddrB   = 2'd1;
  localparam logic [AddrW-1:0] AddrC   = 2'd2;
  localparam logic [AddrW-1:0] AddrCtl = 2'd3;

  localparam logic [PortW-1:0] CtlReset = 8'h9B;

  // port C pin roles used by the handshake modes
  localparam int PinObfA  = 7;
  localparam int PinAckA  = 6;
  localparam int PinIbfA  = 5;
  localparam int PinStbA  = 4;
  localparam int PinIntrA = 3;
  localparam int PinHsB   = 2;  // acknowledge or strobe for B
  localparam int PinBufB  = 1;
  localparam int PinIntrB = 0;

  typedef struct packed {
    logic modeA;
    logic dirA;
    logic dirCh;
    logic modeB;
    logic dirB;
    logic dirCl;
  } cfg_t;

  typedef struct packed {
    logic               wrA;
    logic               wrB;
    logic               wrC;
    logic               clrAll;
    logic               ldA;
    logic               ldB;
    logic               bsrWe;
    logic [BitIdxW-1:0] bsrIdx;
    logic               bsrVal;
  } strb_t;
endpackage

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cs,
  input  logic             rd,
  input  logic             wr,
  input  logic [AddrW-1:0] addr,
  input  logic [PortW-1:0] wdata,
  input  logic [2:0]       hsPinIn,   // {C6, C4, C2}
  output cfg_t             cfg,
  output logic [PortW-1:0] ctlByte,
  output strb_t            strb,
  output logic [PortW-1:0] hsOut,
  output logic [PortW-1:0] hsIn,
  output logic [PortW-1:0] hsVal
);
  logic busWr, busRd, modeWr, bsrWr, rdAEv, rdBEv;
  logic prevAckA, prevStbA, prevHsB;
  logic ackFallA, ackRiseA, stbFallA, stbRiseA, hsFallB, hsRiseB;
  logic obfAN, ibfA, intrA, obfBN, ibfB, intrB;
  logic outHsA, inHsA, outHsB, inHsB;

  assign busWr  = cs & wr;
  assign busRd  = cs & rd;
  assign modeWr = busWr && (addr == AddrCtl) && wdata[PortW-1];
  assign bsrWr  = busWr && (addr == AddrCtl) && !wdata[PortW-1];
  assign rdAEv  = busRd && (addr == AddrA);
  assign rdBEv  = busRd && (addr == AddrB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctlByte <= CtlReset;
    else if (modeWr) ctlByte <= wdata;
  end

  assign cfg.modeA = ctlByte[5];
  assign cfg.dirA  = ctlByte[4];
  assign cfg.dirCh = ctlByte[3];
  assign cfg.modeB = ctlByte[2];
  assign cfg.dirB  = ctlByte[1];
  assign cfg.dirCl = ctlByte[0];

  assign outHsA = cfg.modeA && !cfg.dirA;
  assign inHsA  = cfg.modeA &&  cfg.dirA;
  assign outHsB = cfg.modeB && !cfg.dirB;
  assign inHsB  = cfg.modeB &&  cfg.dirB;

  // edge detection on handshake inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAckA <= 1'b1;
      prevStbA <= 1'b1;
      prevHsB  <= 1'b1;
    end else begin
      prevAckA <= hsPinIn[2];
      prevStbA <= hsPinIn[1];
      prevHsB  <= hsPinIn[0];
    end
  end

  assign ackFallA = prevAckA & ~hsPinIn[2];
  assign ackRiseA = ~prevAckA & hsPinIn[2];
  assign stbFallA = prevStbA & ~hsPinIn[1];
  assign stbRiseA = ~prevStbA & hsPinIn[1];
  assign hsFallB  = prevHsB & ~hsPinIn[0];
  assign hsRiseB  = ~prevHsB & hsPinIn[0];

  // port A handshake flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      obfAN <= 1'b1;
      ibfA  <= 1'b0;
      intrA <= 1'b0;
    end else if (modeWr) begin
      obfAN <= 1'b1;
      ibfA  <= 1'b0;
      intrA <= 1'b0;
    end else if (outHsA) begin
      if (strb.wrA) begin
        obfAN <= 1'b0;
        intrA <= 1'b0;
      end else begin
        if (ackFallA) obfAN <= 1'b1;
        if (ackRiseA && obfAN) intrA <= 1'b1;
      end
    end else if (inHsA) begin
      if (stbFallA) ibfA <= 1'b1;
      if (stbRiseA) intrA <= 1'b1;
      if (rdAEv) begin
        ibfA  <= 1'b0;
        intrA <= 1'b0;
      end
    end
  end

  // port B handshake flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      obfBN <= 1'b1;
      ibfB  <= 1'b0;
      intrB <= 1'b0;
    end else if (modeWr) begin
      obfBN <= 1'b1;
      ibfB  <= 1'b0;
      intrB <= 1'b0;
    end else if (outHsB) begin
      if (strb.wrB) begin
        obfBN <= 1'b0;
        intrB <= 1'b0;
      end else begin
        if (hsFallB) obfBN <= 1'b1;
        if (hsRiseB && obfBN) intrB <= 1'b1;
      end
    end else if (inHsB) begin
      if (hsFallB) ibfB <= 1'b1;
      if (hsRiseB) intrB <= 1'b1;
      if (rdBEv) begin
        ibfB  <= 1'b0;
        intrB <= 1'b0;
      end
    end
  end

  // strobes to the datapath
  always_comb begin
    strb        = '0;
    strb.wrA    = busWr && (addr == AddrA);
    strb.wrB    = busWr && (addr == AddrB);
    strb.wrC    = busWr && (addr == AddrC);
    strb.clrAll = modeWr;
    strb.ldA    = inHsA && stbFallA && !modeWr;
    strb.ldB    = inHsB && hsFallB && !modeWr;
    strb.bsrWe  = bsrWr;
    strb.bsrIdx = wdata[BitIdxW:1];
    strb.bsrVal = wdata[0];
  end

  // port C pin roles
  always_comb begin
    hsOut = '0;
    hsIn  = '0;
    hsVal = '0;
    if (outHsA) begin
      hsOut[PinObfA]  = 1'b1;
      hsOut[PinIntrA] = 1'b1;
      hsIn[PinAckA]   = 1'b1;
      hsVal[PinObfA]  = obfAN;
      hsVal[PinIntrA] = intrA;
    end else if (inHsA) begin
      hsOut[PinIbfA]  = 1'b1;
      hsOut[PinIntrA] = 1'b1;
      hsIn[PinStbA]   = 1'b1;
      hsVal[PinIbfA]  = ibfA;
      hsVal[PinIntrA] = intrA;
    end
    if (cfg.modeB) begin
      hsOut[PinBufB]  = 1'b1;
      hsOut[PinIntrB] = 1'b1;
      hsIn[PinHsB]    = 1'b1;
      hsVal[PinBufB]  = cfg.dirB ? ibfB : obfBN;
      hsVal[PinIntrB] = intrB;
    end
  end

  AST_OBF_A_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrA && outHsA) |=> !obfAN);  // R6
  AST_OBF_B_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrB && outHsB) |=> !obfBN);  // R7
  AST_IBF_A_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (inHsA && stbFallA && !rdAEv && !modeWr) |=> ibfA);  // R8
  AST_READ_A_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (inHsA && rdAEv && !modeWr) |=> (!ibfA && !intrA));  // R8
  AST_IBF_B_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (inHsB && hsFallB && !rdBEv && !modeWr) |=> ibfB);  // R9
  AST_MODE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    modeWr |=> (obfAN && obfBN && !ibfA && !ibfB && !intrA && !intrB));  // R4
  AST_BSR_KEEPS_CTL: assert property (@(posedge clk) disable iff (!rstN)
    bsrWr |=> $stable(ctlByte));  // R5
endmodule

// File: rtl/pport_data.sv
module pport_data
  import pport_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strb_t            strb,
  input  cfg_t             cfg,
  input  logic [PortW-1:0] ctlByte,
  input  logic [PortW-1:0] wdata,
  input  logic [AddrW-1:0] addr,
  input  logic             rdEn,
  input  logic [PortW-1:0] aIn,
  input  logic [PortW-1:0] bIn,
  input  logic [PortW-1:0] cIn,
  input  logic [PortW-1:0] hsOut,
  input  logic [PortW-1:0] hsIn,
  input  logic [PortW-1:0] hsVal,
  output logic [PortW-1:0] aOut,
  output logic [PortW-1:0] aOe,
  output logic [PortW-1:0] bOut,
  output logic [PortW-1:0] bOe,
  output logic [PortW-1:0] cOut,
  output logic [PortW-1:0] cOe,
  output logic [PortW-1:0] rdata
);
  logic [PortW-1:0] aLat, bLat, cLat, aInLat, bInLat;
  logic [PortW-1:0] aRead, bRead, cRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aLat   <= '0;
      bLat   <= '0;
      cLat   <= '0;
      aInLat <= '0;
      bInLat <= '0;
    end else if (strb.clrAll) begin
      aLat   <= '0;
      bLat   <= '0;
      cLat   <= '0;
      aInLat <= '0;
      bInLat <= '0;
    end else begin
      if (strb.wrA) aLat <= wdata;
      if (strb.wrB) bLat <= wdata;
      if (strb.wrC) cLat <= wdata;
      else if (strb.bsrWe) cLat[strb.bsrIdx] <= strb.bsrVal;
      if (strb.ldA) aInLat <= aIn;
      if (strb.ldB) bInLat <= bIn;
    end
  end

  assign aOut = aLat;
  assign bOut = bLat;
  assign aOe  = cfg.dirA ? '0 : '1;
  assign bOe  = cfg.dirB ? '0 : '1;

  assign aRead = cfg.dirA ? (cfg.modeA ? aInLat : aIn) : aLat;
  assign bRead = cfg.dirB ? (cfg.modeB ? bInLat : bIn) : bLat;

  for (genvar i = 0; i < PortW; i++) begin : g_cbit
    logic halfIn;
    if (i >= HalfW) begin : g_hi
      assign halfIn = cfg.dirCh;
    end else begin : g_lo
      assign halfIn = cfg.dirCl;
    end
    assign cOe[i]   = hsOut[i] | (~hsIn[i] & ~halfIn);
    assign cOut[i]  = hsOut[i] ? hsVal[i] : cLat[i];
    assign cRead[i] = cOe[i] ? cOut[i] : cIn[i];
  end

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      unique case (addr)
        AddrA:   rdata = aRead;
        AddrB:   rdata = bRead;
        AddrC:   rdata = cRead;
        default: rdata = ctlByte;
      endcase
    end
  end

  AST_MODE_CLEARS_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (aLat == '0 && bLat == '0 && cLat == '0));  // R4
  AST_BSR_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bsrWe && !strb.clrAll) |=> ($countones(cLat ^ $past(cLat)) <= 1));  // R5
  AST_A_INPUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ldA && !strb.clrAll) |=> $stable(aInLat));  // R8
endmodule

// File: rtl/hsk_pport.sv
module hsk_pport
  import pport_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cs,
  input  logic             rd,
  input  logic             wr,
  input  logic [AddrW-1:0] addr,
  input  logic [PortW-1:0] wdata,
  output logic [PortW-1:0] rdata,
  input  logic [PortW-1:0] aIn,
  output logic [PortW-1:0] aOut,
  output logic [PortW-1:0] aOe,
  input  logic [PortW-1:0] bIn,
  output logic [PortW-1:0] bOut,
  output logic [PortW-1:0] bOe,
  input  logic [PortW-1:0] cIn,
  output logic [PortW-1:0] cOut,
  output logic [PortW-1:0] cOe
);
  cfg_t             cfg;
  strb_t            strb;
  logic [PortW-1:0] ctlByte, hsOut, hsIn, hsVal;

  pport_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .cs      (cs),
    .rd      (rd),
    .wr      (wr),
    .addr    (addr),
    .wdata   (wdata),
    .hsPinIn ({cIn[PinAckA], cIn[PinStbA], cIn[PinHsB]}),
    .cfg     (cfg),
    .ctlByte (ctlByte),
    .strb    (strb),
    .hsOut   (hsOut),
    .hsIn    (hsIn),
    .hsVal   (hsVal)
  );

  pport_data data_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfg     (cfg),
    .ctlByte (ctlByte),
    .wdata   (wdata),
    .addr    (addr),
    .rdEn    (cs & rd),
    .aIn     (aIn),
    .bIn     (bIn),
    .cIn     (cIn),
    .hsOut   (hsOut),
    .hsIn    (hsIn),
    .hsVal   (hsVal),
    .aOut    (aOut),
    .aOe     (aOe),
    .bOut    (bOut),
    .bOe     (bOe),
    .cOut    (cOut),
    .cOe     (cOe),
    .rdata   (rdata)
  );
endmodule

// File: tb/hsk_pport_tb_top.sv
`timescale 1ns/1ps
module hsk_pport_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] aIn = '0, bIn = '0, cIn = 8'hFF;
  logic [7:0] aOut, aOe, bOut, bOe, cOut, cOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hsk_pport dut_i (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .cIn(cIn), .cOut(cOut), .cOe(cOe)
  );

  typedef struct packed {
    logic [7:0] ctl, wA, wB, wC, pA, pB, pC, eA, eB, eC, oeA, oeB, oeC;
  } row_t;

  localparam int NumRows = 6;
  localparam row_t Rows [NumRows] = '{
    '{8'h80, 8'h3C, 8'hA5, 8'h96, 8'h11, 8'h22, 8'h33, 8'h3C, 8'hA5, 8'h96, 8'hFF, 8'hFF, 8'hFF},
    '{8'h9B, 8'h3C, 8'hA5, 8'h96, 8'h11, 8'h22, 8'h33, 8'h11, 8'h22, 8'h33, 8'h00, 8'h00, 8'h00},
    '{8'h88, 8'h3C, 8'hA5, 8'h96, 8'h11, 8'h22, 8'h5A, 8'h3C, 8'hA5, 8'h56, 8'hFF, 8'hFF, 8'h0F},
    '{8'h81, 8'h3C, 8'hA5, 8'h96, 8'h11, 8'h22, 8'h5A, 8'h3C, 8'hA5, 8'h9A, 8'hFF, 8'hFF, 8'hF0},
    '{8'h92, 8'h3C, 8'hA5, 8'h96, 8'hC3, 8'h7E, 8'h00, 8'hC3, 8'h7E, 8'h96, 8'h00, 8'h00, 8'hFF},
    '{8'hC0, 8'h3C, 8'hA5, 8'h96, 8'h11, 8'h22, 8'h33, 8'h3C, 8'hA5, 8'h96, 8'hFF, 8'hFF, 8'hFF}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    #1;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #2 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    #1;
  endtask

  task automatic pinC(input int idx, input logic v);
    @(negedge clk);
    cIn[idx] = v;
    @(negedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10 reset state
    chk("R10 aOe", aOe, 8'h00);
    chk("R10 bOe", bOe, 8'h00);
    chk("R10 cOe", cOe, 8'h00);
    chk("R10 aOut", aOut, 8'h00);
    chk("R10 cOut", cOut, 8'h00);
    busRead(2'd3, d);
    chk("R10 ctl", d, 8'h9B);

    // table of plain-mode configurations: R1 R2 R3
    for (int i = 0; i < NumRows; i++) begin
      busWrite(2'd3, Rows[i].ctl);
      busWrite(2'd0, Rows[i].wA);
      busWrite(2'd1, Rows[i].wB);
      busWrite(2'd2, Rows[i].wC);
      aIn = Rows[i].pA; bIn = Rows[i].pB; cIn = Rows[i].pC;
      busRead(2'd0, d); chk("R3 read A", d, Rows[i].eA);
      busRead(2'd1, d); chk("R3 read B", d, Rows[i].eB);
      busRead(2'd2, d); chk("R3 read C", d, Rows[i].eC);
      busRead(2'd3, d); chk("R1 read ctl", d, Rows[i].ctl);
      chk("R2 aOe", aOe, Rows[i].oeA);
      chk("R2 bOe", bOe, Rows[i].oeB);
      chk("R2 cOe", cOe, Rows[i].oeC);
      chk("R2 aOut", aOut, Rows[i].wA);
      chk("R2 bOut", bOut, Rows[i].wB);
    end

    // R4: mode word clears latches
    busWrite(2'd3, 8'h80);
    chk("R4 aOut", aOut, 8'h00);
    chk("R4 bOut", bOut, 8'h00);
    chk("R4 cOut", cOut, 8'h00);

    // R5: single-bit set/reset of port C
    busWrite(2'd2, 8'h21);
    busWrite(2'd3, 8'h09);
    chk("R5 set bit4", cOut, 8'h31);
    busWrite(2'd3, 8'h0F);
    chk("R5 set bit7", cOut, 8'hB1);
    busWrite(2'd3, 8'h08);
    chk("R5 clr bit4", cOut, 8'hA1);
    busWrite(2'd3, 8'h0A);
    chk("R5 clr bit5", cOut, 8'h81);
    busRead(2'd3, d);
    chk("R5 ctl kept", d, 8'h80);

    // R6: port A handshake output
    cIn = 8'hFF;
    busWrite(2'd3, 8'hA0);
    chk("R6 idle cOut", cOut, 8'h80);
    chk("R6 cOe", cOe, 8'hBF);
    busWrite(2'd0, 8'h5E);
    chk("R6 aOut", aOut, 8'h5E);
    chk("R6 obf low", cOut & 8'h88, 8'h00);
    pinC(6, 1'b0);
    chk("R6 obf high on ack fall", cOut & 8'h88, 8'h80);
    pinC(6, 1'b1);
    chk("R6 intr on ack rise", cOut & 8'h88, 8'h88);
    busWrite(2'd0, 8'h61);
    chk("R6 write clears intr", cOut & 8'h88, 8'h00);

    // R7: port B handshake output
    cIn = 8'hFF;
    busWrite(2'd3, 8'h84);
    chk("R7 cOe", cOe, 8'hFB);
    busWrite(2'd1, 8'hC7);
    chk("R7 obf low", cOut & 8'h03, 8'h00);
    pinC(2, 1'b0);
    chk("R7 obf high on ack fall", cOut & 8'h03, 8'h02);
    pinC(2, 1'b1);
    chk("R7 intr on ack rise", cOut & 8'h03, 8'h03);

    // R8: port A handshake input
    cIn = 8'hFF;
    busWrite(2'd3, 8'hB0);
    chk("R8 aOe", aOe, 8'h00);
    chk("R8 flags idle", cOut & 8'h28, 8'h00);
    aIn = 8'h6D;
    pinC(4, 1'b0);
    chk("R8 ibf on strobe fall", cOut & 8'h28, 8'h20);
    aIn = 8'h00;
    pinC(4, 1'b1);
    chk("R8 intr on strobe rise", cOut & 8'h28, 8'h28);
    busRead(2'd0, d);
    chk("R8 latched data", d, 8'h6D);
    chk("R8 read clears flags", cOut & 8'h28, 8'h00);

    // R9: port B handshake input
    cIn = 8'hFF;
    busWrite(2'd3, 8'h86);
    chk("R9 bOe", bOe, 8'h00);
    bIn = 8'hB4;
    pinC(2, 1'b0);
    chk("R9 ibf on strobe fall", cOut & 8'h03, 8'h02);
    bIn = 8'h0F;
    pinC(2, 1'b1);
    chk("R9 intr on strobe rise", cOut & 8'h03, 8'h03);
    busRead(2'd1, d);
    chk("R9 latched data", d, 8'hB4);
    chk("R9 read clears flags", cOut & 8'h03, 8'h00);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule